// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block keeps the interrupt bookkeeping for a pair of serial channels, called A (index 0) and B (index 1). Each channel reports a received character, a transmit byte that has left the buffer, data-port reads and data-port writes. Each channel also accepts a command field. The block records a receive source and a transmit source per channel, with an in-service flag for each. From these it drives one shared interrupt request line, a readable pending register and a readable vector register.

A received character enters service at once. While that receive interrupt is in service, a newly arriving transmit interrupt for the same channel is held back. It is recorded, but it reaches neither the pending register nor the vector. It is posted later, when the receive side is read, when the in-service flag is reset, or when the transmit source is cleared and posted again. The vector reports the highest-priority posted source. A mode input selects one of two bit encodings for it.

Within one clock cycle, simultaneous events on a channel take effect in this order: character arrival, data read, data write, transmit byte consumed, command. Every result is visible on the outputs one clock edge after its event.

Top module: `dual_chan_irq_ctl`

## Requirements
- R1: After reset, or a reset in mid-operation, `irq`=0, `pend_reg`=0x00, `vec_reg`=0x06 in low-status mode, `rx_avail`=00 and `tx_empty`=11.
- R2: `pend_reg` bit 5 is receive A, bit 4 is transmit A (posted and enabled), bit 2 is receive B and bit 1 is transmit B. All other bits read 0.
- R3: With `stat_hi`=0, `vec_reg` is 0x0C for receive A, 0x08 for transmit A, 0x04 for receive B, 0x00 for transmit B and 0x06 for none. The priority order is receive A, transmit A, receive B, transmit B.
- R4: With `stat_hi`=1, `vec_reg` is 0x30 for receive A, 0x10 for transmit A, 0x20 for receive B, 0x00 for transmit B and 0x60 for none, with the same priority order.
- R5: A received character sets that channel's receive-available, receive-pending and receive-in-service flags on the next edge.
- R6: A transmit byte consumed while the channel's receive interrupt is in service sets transmit pending, but the source is not posted to `pend_reg` or `vec_reg`.
- R7: Command field 3'b111 (reset highest in service) clears the receive in-service flag and posts a pending transmit source. When no receive source is in service, it clears only the transmit in-service flag, which leaves `pend_reg` unchanged.
- R8: Command field 3'b101 clears the channel's transmit source and re-posts a still-pending receive source. Every other command field value leaves all outputs unchanged.
- R9: A channel requests when `tx_ie` is set with transmit pending, when its receive mode is 2'b01 or 2'b10 with receive pending, or when its `brk_ie` and `brk_status` are both set.
- R10: `irq` is the OR of the two channel request terms.
- R11: A data write clears transmit pending and `tx_empty`. A consumed transmit byte sets `tx_empty` and raises the transmit source.
- R12: A data read clears receive-available and the receive source, and posts a waiting transmit source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_hi | input | 1 | Vector encoding select: 1 selects high-status codes |
| tx_ie | input | 2 | Transmit interrupt enable, one bit per channel |
| rx_mode_a | input | 2 | Receive interrupt mode for channel A |
| rx_mode_b | input | 2 | Receive interrupt mode for channel B |
| brk_ie | input | 2 | Break interrupt enable, one bit per channel |
| brk_status | input | 2 | Break condition level, one bit per channel |
| rx_char_ev | input | 2 | One-cycle pulse: a character has arrived |
| tx_done_ev | input | 2 | One-cycle pulse: a transmit byte has been consumed |
| data_wr | input | 2 | One-cycle pulse: data-port write |
| data_rd | input | 2 | One-cycle pulse: data-port read |
| cmd_wr | input | 2 | One-cycle pulse: command write, one bit per channel |
| cmd_field | input | 3 | Command code carried by `cmd_wr` |
| irq | output | 1 | Combined interrupt request |
| pend_reg | output | 8 | Interrupt pending register |
| vec_reg | output | 8 | Shared interrupt vector |
| rx_avail | output | 2 | Receive character available, per channel |
| tx_empty | output | 2 | Transmit buffer empty, per channel |

## Verification
The scripted sequence takes each channel through four cases. In the first, transmit is raised alone. In the second, transmit arrives while a receive is in service. In the third, the service flag is reset, with and without a receive source in service. In the fourth, the transmit source is cleared by command. Together these separate posting from pending, and masking from plain priority. The sequence runs once in each vector encoding and with both channels active together, so cross-channel priority is distinguished from per-channel state. Directed cases then vary the receive mode, the transmit enable, unused command codes and break inputs one at a time, confirming that each gates only the request line or nothing. A final case resets the block in mid-operation.

// File: rtl/dci_pkg.sv
package dci_pkg;

  localparam int NCH    = 2;
  localparam int REG_W  = 8;
  localparam int CMD_W  = 3;
  localparam int MODE_W = 2;

  localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'b111;

  typedef enum logic [2:0] {
    SRC_RX_A = 3'd0,
    SRC_TX_A = 3'd1,
    SRC_RX_B = 3'd2,
    SRC_TX_B = 3'd3,
    SRC_NONE = 3'd4
  } src_e;

  typedef struct packed {
    logic rx_av;
    logic rx_pend;
    logic rx_ius;
    logic tx_emp;
    logic tx_pend;
    logic tx_ius;
    logic tx_post;
  } chan_st_t;

  // Receive interrupts are armed for the two middle mode codes only.
  function automatic logic rx_mode_arms(input logic [MODE_W-1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  // Fixed priority: rx A, tx A, rx B, tx B.
  function automatic src_e pick_src(input logic [NCH-1:0] rxp,
                                    input logic [NCH-1:0] txp);
    if (rxp[0])      return SRC_RX_A;
    else if (txp[0]) return SRC_TX_A;
    else if (rxp[1]) return SRC_RX_B;
    else if (txp[1]) return SRC_TX_B;
    else             return SRC_NONE;
  endfunction

  function automatic logic [REG_W-1:0] vec_code(input src_e s, input logic hi);
    logic [REG_W-1:0] v;
    case (s)
      SRC_RX_A: v = hi ? 8'h30 : 8'h0C;
      SRC_TX_A: v = hi ? 8'h10 : 8'h08;
      SRC_RX_B: v = hi ? 8'h20 : 8'h04;
      SRC_TX_B: v = 8'h00;
      default:  v = hi ? 8'h60 : 8'h06;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dci_cmd_decode.sv
module dci_cmd_decode
  import dci_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_field,
  output logic             clr_tx,
  output logic             rst_ius
);

  // Only two codes act; every other code is dropped here.
  assign clr_tx  = cmd_wr && (cmd_field == CMD_CLR_TX);
  assign rst_ius = cmd_wr && (cmd_field == CMD_RST_IUS);

endmodule

// File: rtl/dci_chan_state.sv
module dci_chan_state
  import dci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_ev,
  input  logic              rd,
  input  logic              wr,
  input  logic              tx_done,
  input  logic              clr_tx,
  input  logic              rst_ius,
  input  logic              tx_ie,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic              brk_ie,
  input  logic              brk_st,
  output chan_st_t          st,
  output logic              req
);

  chan_st_t q, n;

  localparam chan_st_t RESET_ST = '{rx_av: 1'b0, rx_pend: 1'b0, rx_ius: 1'b0,
                                    tx_emp: 1'b1, tx_pend: 1'b0, tx_ius: 1'b0,
                                    tx_post: 1'b0};

  // Events applied as ordered steps on one working copy of the state.
  always_comb begin
    n = q;
    if (rx_ev) begin
      n.rx_av   = 1'b1;
      n.rx_pend = 1'b1;
      n.rx_ius  = 1'b1;
    end
    if (rd) begin
      n.rx_av   = 1'b0;
      n.rx_pend = 1'b0;
      n.rx_ius  = 1'b0;
      if (n.tx_pend) begin
        n.tx_ius  = 1'b1;
        n.tx_post = 1'b1;
      end
    end
    if (wr) begin
      n.tx_emp  = 1'b0;
      n.tx_pend = 1'b0;
      n.tx_ius  = 1'b0;
      n.tx_post = 1'b0;
    end
    if (tx_done) begin
      n.tx_emp  = 1'b1;
      n.tx_pend = 1'b1;
      if (!n.rx_ius) begin
        n.tx_ius  = 1'b1;
        n.tx_post = 1'b1;
      end
    end
    if (clr_tx) begin
      n.tx_pend = 1'b0;
      n.tx_ius  = 1'b0;
      n.tx_post = 1'b0;
      if (n.rx_pend) n.rx_ius = 1'b1;
    end
    if (rst_ius) begin
      if (n.rx_ius) begin
        n.rx_ius = 1'b0;
        if (n.tx_pend) begin
          n.tx_ius  = 1'b1;
          n.tx_post = 1'b1;
        end
      end else if (n.tx_ius) begin
        n.tx_ius = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_ST;
    else        q <= n;
  end

  assign st  = q;
  assign req = (tx_ie && q.tx_pend) ||
               (rx_mode_arms(rx_mode) && q.rx_pend) ||
               (brk_ie && brk_st);

  AST_RX_ENTERS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ev && !rd && !rst_ius |=> st.rx_pend && st.rx_ius); // R5
  AST_TX_HELD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.tx_ius) |-> !st.rx_ius); // R6
  AST_IUS_CMD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ius |=> !st.rx_ius); // R7
  AST_CLRTX_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx && !tx_done |=> !st.tx_pend && !st.tx_post); // R8
  AST_WR_DROPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !tx_done |=> !st.tx_pend && !st.tx_emp); // R11
  AST_RD_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !rx_ev |=> !st.rx_av && !st.rx_pend); // R12

endmodule

// File: rtl/dci_vec_encode.sv
module dci_vec_encode
  import dci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rx_pend,
  input  logic [NCH-1:0]   tx_post,
  input  logic [NCH-1:0]   tx_ie,
  input  logic             stat_hi,
  output logic [REG_W-1:0] pend,
  output logic [REG_W-1:0] vec
);

  localparam int BIT_RX_A = 5;
  localparam int BIT_TX_A = 4;
  localparam int BIT_RX_B = 2;
  localparam int BIT_TX_B = 1;

  src_e top_src;

  always_comb begin
    pend           = '0;
    pend[BIT_RX_A] = rx_pend[0];
    pend[BIT_TX_A] = tx_post[0] && tx_ie[0];
    pend[BIT_RX_B] = rx_pend[1];
    pend[BIT_TX_B] = tx_post[1] && tx_ie[1];
  end

  assign top_src = pick_src(rx_pend, tx_post);
  assign vec     = vec_code(top_src, stat_hi);

  AST_VEC_RX_A: assert property (@(posedge clk) disable iff (!rst_n)
    pend[BIT_RX_A] |-> (vec == 8'h0C || vec == 8'h30)); // R3
  AST_VEC_IDLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend == '0 && tx_post == '0 && stat_hi) |-> vec == 8'h60); // R4

endmodule

// File: rtl/dual_chan_irq_ctl.sv
module dual_chan_irq_ctl
  import dci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_hi,
  input  logic [1:0]       tx_ie,
  input  logic [1:0]       rx_mode_a,
  input  logic [1:0]       rx_mode_b,
  input  logic [1:0]       brk_ie,
  input  logic [1:0]       brk_status,
  input  logic [1:0]       rx_char_ev,
  input  logic [1:0]       tx_done_ev,
  input  logic [1:0]       data_wr,
  input  logic [1:0]       data_rd,
  input  logic [1:0]       cmd_wr,
  input  logic [2:0]       cmd_field,
  output logic             irq,
  output logic [7:0]       pend_reg,
  output logic [7:0]       vec_reg,
  output logic [1:0]       rx_avail,
  output logic [1:0]       tx_empty
);

  logic [MODE_W-1:0] rx_mode_v [NCH];
  chan_st_t          st_v      [NCH];
  logic [NCH-1:0]    req_v;
  logic [NCH-1:0]    clr_tx_v;
  logic [NCH-1:0]    rst_ius_v;
  logic [NCH-1:0]    rx_pend_v;
  logic [NCH-1:0]    tx_post_v;

  assign rx_mode_v[0] = rx_mode_a;
  assign rx_mode_v[1] = rx_mode_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dci_cmd_decode u_dec (
      .cmd_wr    (cmd_wr[c]),
      .cmd_field (cmd_field),
      .clr_tx    (clr_tx_v[c]),
      .rst_ius   (rst_ius_v[c])
    );

    dci_chan_state u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_ev   (rx_char_ev[c]),
      .rd      (data_rd[c]),
      .wr      (data_wr[c]),
      .tx_done (tx_done_ev[c]),
      .clr_tx  (clr_tx_v[c]),
      .rst_ius (rst_ius_v[c]),
      .tx_ie   (tx_ie[c]),
      .rx_mode (rx_mode_v[c]),
      .brk_ie  (brk_ie[c]),
      .brk_st  (brk_status[c]),
      .st      (st_v[c]),
      .req     (req_v[c])
    );

    assign rx_pend_v[c] = st_v[c].rx_pend;
    assign tx_post_v[c] = st_v[c].tx_post;
    assign rx_avail[c]  = st_v[c].rx_av;
    assign tx_empty[c]  = st_v[c].tx_emp;
  end

  dci_vec_encode u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_pend (rx_pend_v),
    .tx_post (tx_post_v),
    .tx_ie   (tx_ie),
    .stat_hi (stat_hi),
    .pend    (pend_reg),
    .vec     (vec_reg)
  );

  assign irq = |req_v;

endmodule

// File: tb/dual_chan_irq_ctl_bench.sv
`timescale 1ns/1ps
module dual_chan_irq_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stat_hi;
  logic [1:0] tx_ie, rx_mode_a, rx_mode_b, brk_ie, brk_status;
  logic [1:0] rx_char_ev, tx_done_ev, data_wr, data_rd, cmd_wr;
  logic [2:0] cmd_field;
  logic       irq;
  logic [7:0] pend_reg, vec_reg;
  logic [1:0] rx_avail, tx_empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dual_chan_irq_ctl u_dual_chan_irq_ctl (
    .clk(clk), .rst_n(rst_n), .stat_hi(stat_hi), .tx_ie(tx_ie),
    .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b), .brk_ie(brk_ie),
    .brk_status(brk_status), .rx_char_ev(rx_char_ev), .tx_done_ev(tx_done_ev),
    .data_wr(data_wr), .data_rd(data_rd), .cmd_wr(cmd_wr), .cmd_field(cmd_field),
    .irq(irq), .pend_reg(pend_reg), .vec_reg(vec_reg),
    .rx_avail(rx_avail), .tx_empty(tx_empty)
  );

  // {stat_hi, rx_ev, rd, wr, tx_done, cmd_wr, cmd_field, exp_irq, exp_pend, exp_vec}
  localparam int NV = 20;
  localparam logic [30:0] TBL [NV] = '{
    {1'b0,2'b00,2'b00,2'b00,2'b01,2'b00,3'b000,1'b1,8'h10,8'h08}, // R11 R3 tx A alone
    {1'b0,2'b01,2'b00,2'b00,2'b00,2'b00,3'b000,1'b1,8'h30,8'h0C}, // R5 rx A over tx A
    {1'b0,2'b00,2'b00,2'b00,2'b00,2'b01,3'b101,1'b1,8'h20,8'h0C}, // R8 clear tx A
    {1'b0,2'b00,2'b00,2'b00,2'b01,2'b00,3'b000,1'b1,8'h20,8'h0C}, // R6 tx held back
    {1'b0,2'b00,2'b01,2'b00,2'b00,2'b00,3'b000,1'b1,8'h10,8'h08}, // R12 read posts tx
    {1'b0,2'b00,2'b00,2'b01,2'b00,2'b00,3'b000,1'b0,8'h00,8'h06}, // R11 write clears
    {1'b0,2'b10,2'b00,2'b00,2'b00,2'b00,3'b000,1'b1,8'h04,8'h04}, // R5 rx B
    {1'b0,2'b00,2'b00,2'b00,2'b10,2'b00,3'b000,1'b1,8'h04,8'h04}, // R6 tx B held
    {1'b0,2'b00,2'b00,2'b00,2'b00,2'b10,3'b111,1'b1,8'h06,8'h04}, // R7 ius reset posts
    {1'b0,2'b00,2'b10,2'b00,2'b00,2'b00,3'b000,1'b1,8'h02,8'h00}, // R12 R3 tx B
    {1'b0,2'b00,2'b00,2'b00,2'b00,2'b10,3'b111,1'b1,8'h02,8'h00}, // R7 tx ius only
    {1'b0,2'b00,2'b00,2'b00,2'b00,2'b10,3'b101,1'b0,8'h00,8'h06}, // R8 clear tx B
    {1'b1,2'b01,2'b00,2'b00,2'b10,2'b00,3'b000,1'b1,8'h22,8'h30}, // R4 R2 both
    {1'b1,2'b00,2'b00,2'b00,2'b00,2'b01,3'b111,1'b1,8'h22,8'h30}, // R7 no tx waiting
    {1'b1,2'b00,2'b01,2'b00,2'b00,2'b00,3'b000,1'b1,8'h02,8'h00}, // R4 tx B
    {1'b1,2'b00,2'b00,2'b10,2'b00,2'b00,3'b000,1'b0,8'h00,8'h60}, // R4 none
    {1'b1,2'b00,2'b00,2'b00,2'b01,2'b00,3'b000,1'b1,8'h10,8'h10}, // R4 tx A
    {1'b1,2'b10,2'b00,2'b00,2'b00,2'b00,3'b000,1'b1,8'h14,8'h10}, // R4 priority
    {1'b1,2'b00,2'b00,2'b01,2'b00,2'b00,3'b000,1'b1,8'h04,8'h20}, // R4 rx B
    {1'b1,2'b00,2'b10,2'b00,2'b00,2'b00,3'b000,1'b0,8'h00,8'h60}  // R10 idle
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clr_pulses();
    rx_char_ev = '0; tx_done_ev = '0; data_wr = '0; data_rd = '0;
    cmd_wr = '0; cmd_field = '0;
  endtask

  // Pulse inputs for one edge, then sample 1 ns after it.
  task automatic step(input logic [1:0] rxe, input logic [1:0] rd, input logic [1:0] wr,
                      input logic [1:0] txd, input logic [1:0] cw, input logic [2:0] cf);
    @(negedge clk);
    rx_char_ev = rxe; data_rd = rd; data_wr = wr; tx_done_ev = txd;
    cmd_wr = cw; cmd_field = cf;
    @(posedge clk);
    #1;
    clr_pulses();
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stat_hi = 1'b0; tx_ie = 2'b11; rx_mode_a = 2'b01; rx_mode_b = 2'b10;
    brk_ie = 2'b00; brk_status = 2'b00;
    clr_pulses();
    repeat (3) @(posedge clk);
    settle();
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pend", pend_reg, 8'h00);
    chk("R1 vec", vec_reg, 8'h06);
    chk("R1 rx_avail", {6'd0, rx_avail}, 8'h00);
    chk("R1 tx_empty", {6'd0, tx_empty}, 8'h03);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] e;
      e = TBL[i];
      @(negedge clk);
      stat_hi = e[30];
      step(e[29:28], e[27:26], e[25:24], e[23:22], e[21:20], e[19:17]);
      chk($sformatf("R2/R3/R4 row %0d irq", i), {7'd0, irq}, {7'd0, e[16]});
      chk($sformatf("R2 row %0d pend", i), pend_reg, e[15:8]);
      chk($sformatf("R3/R4 row %0d vec", i), vec_reg, e[7:0]);
    end
    chk("R11 tx_empty after writes", {6'd0, tx_empty}, 8'h00);

    // R9 receive mode gating
    stat_hi = 1'b0;
    rx_mode_a = 2'b00;
    step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000);
    chk("R9 mode00 irq", {7'd0, irq}, 8'h00);
    chk("R5 pend rxA", pend_reg, 8'h20);
    chk("R5 rx_avail", {6'd0, rx_avail}, 8'h01);
    settle(); rx_mode_a = 2'b11; #1;
    chk("R9 mode11 irq", {7'd0, irq}, 8'h00);
    rx_mode_a = 2'b01; #1;
    chk("R9 mode01 irq", {7'd0, irq}, 8'h01);
    step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 3'b000);
    chk("R12 rx_avail cleared", {6'd0, rx_avail}, 8'h00);
    chk("R12 irq cleared", {7'd0, irq}, 8'h00);

    // R9 transmit enable gating; R8 ignored codes
    tx_ie = 2'b00;
    step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 3'b000);
    chk("R9 tx disabled irq", {7'd0, irq}, 8'h00);
    chk("R2 tx disabled pend", pend_reg, 8'h00);
    chk("R3 vec tx B", vec_reg, 8'h00);
    chk("R11 tx_empty set", {6'd0, tx_empty}, 8'h02);
    settle(); tx_ie = 2'b10; #1;
    chk("R9 tx enabled irq", {7'd0, irq}, 8'h01);
    chk("R2 tx enabled pend", pend_reg, 8'h02);
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 3'b010);
    chk("R8 ignored code pend", pend_reg, 8'h02);
    chk("R8 ignored code irq", {7'd0, irq}, 8'h01);
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 3'b100);
    chk("R8 ignored code2 vec", vec_reg, 8'h00);
    step(2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 3'b000);
    chk("R11 write drops irq", {7'd0, irq}, 8'h00);
    chk("R11 write tx_empty", {6'd0, tx_empty}, 8'h00);
    tx_ie = 2'b11;

    // R9 R10 break term per channel
    settle(); brk_ie = 2'b10; brk_status = 2'b10; #1;
    chk("R10 break B irq", {7'd0, irq}, 8'h01);
    brk_status = 2'b01; #1;
    chk("R9 break A not enabled", {7'd0, irq}, 8'h00);
    brk_ie = 2'b11; #1;
    chk("R10 break A irq", {7'd0, irq}, 8'h01);
    brk_ie = 2'b00; brk_status = 2'b00; #1;
    chk("R9 break off", {7'd0, irq}, 8'h00);

    // R1 reset in mid-operation
    step(2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 3'b000);
    chk("R10 busy irq", {7'd0, irq}, 8'h01);
    settle(); rst_n = 1'b0; #1;
    chk("R1 mid pend", pend_reg, 8'h00);
    chk("R1 mid vec", vec_reg, 8'h06);
    chk("R1 mid irq", {7'd0, irq}, 8'h00);
    chk("R1 mid tx_empty", {6'd0, tx_empty}, 8'h03);
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule